// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Periodic Tick

This block is a timer peripheral built from three cooperating parts. A free-running real-time counter is split into a narrow upper part and a wide lower part. The lower part advances once per clock, and the upper part advances when the lower part carries. Each part can be held on its own, and a clear control forces the whole counter to zero. An alarm comparator watches the full counter width. A reload-style periodic timer produces a regular tick whose interval software picks.

Each part raises its own sticky interrupt flag. Software reaches all of the block through a small register bus with seven word addresses: control, counter low, counter high, alarm low, alarm high, periodic reload and status. Reading the counter low word also latches the upper part into a holding register. A read of the counter high word that follows therefore gives the upper part as it stood at the moment of the low read.

Top module: `rtc_alarm_tick`

## Requirements
- R1: After reset the control, alarm, reload and status registers read zero, and all three interrupt outputs are low. The register addresses are 0 control, 1 counter low, 2 counter high, 3 alarm low, 4 alarm high, 5 reload and 6 status.
- R2: The counter lower part increments by one on every clock while it is neither held nor cleared. When the lower part wraps from all ones, the upper part increments by one.
- R3: Control bit 2 holds the lower part and control bit 3 holds the upper part. While a part is held it keeps its value. A held lower part produces no carry into the upper part.
- R4: While control bit 4 is set, both counter parts read zero and do not advance. Once the bit is cleared, counting restarts from zero.
- R5: A read of address 1 latches the upper part of that same cycle. A later read of address 2 returns the latched value, not the live upper part.
- R6: The alarm compare value is the alarm low word together with the alarm high word, which is masked to the width of the upper part. Status bit 30 is set when the full counter becomes equal to the compare value.
- R7: Control bit 0 enables the periodic timer. When the enable rises, the timer loads the reload value N. It then raises status bit 29 once every N+1 clocks.
- R8: While control bit 1 is set, the periodic countdown holds and raises no tick.
- R9: Status bit 31 is set on the clock edge where the full counter wraps from all ones to zero.
- R10: Status flags stay set until software writes a one to the same bit of address 6. If a new event arrives in the same cycle as that write, the flag stays set. The flags drive irq_rollover, irq_alarm and irq_tick.
- R11: Writing zero to the control register stops the periodic timer and releases all holds and the clear, so that no further tick flags are raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the counter low word latches the upper part |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, valid in the same cycle |
| irq_rollover | output | 1 | Sticky counter wrap flag (status bit 31) |
| irq_alarm | output | 1 | Sticky alarm match flag (status bit 30) |
| irq_tick | output | 1 | Sticky periodic expiry flag (status bit 29) |

## Verification
Some properties are checked on every cycle. A held part keeps its value, a cleared counter reads zero on the next edge and a running lower part steps by one. After a tick the countdown restarts from the reload value, and a held countdown stays still. The latch captures the live upper part on a low read, and an event always wins over a clear of its flag. Other behaviour shows only in the directed scenarios that the bench builds around exact cycle counts. These cover the carry into the upper part after a full lower wrap, the alarm firing on a high-word match but not on a low-only match, and the N+1 tick spacing. They also cover the wrap flag appearing exactly when the full counter wraps, and a read pair that stays consistent across a carry.

// File: rtl/rtc_alarm_tick_pkg.sv
package rtc_alarm_tick_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL   = 3'd0,
    ADDR_CNT_LO = 3'd1,
    ADDR_CNT_HI = 3'd2,
    ADDR_ALM_LO = 3'd3,
    ADDR_ALM_HI = 3'd4,
    ADDR_RELOAD = 3'd5,
    ADDR_STATUS = 3'd6
  } reg_addr_e;

  // control word, bit 0 at the right
  typedef struct packed {
    logic clear;
    logic hold_hi;
    logic hold_lo;
    logic tick_hold;
    logic tick_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam int ST_WRAP  = 31;
  localparam int ST_ALARM = 30;
  localparam int ST_TICK  = 29;

endpackage

// File: rtl/rtc_split_counter.sv
module rtc_split_counter #(
  parameter int HI_W = 8,
  parameter int LO_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            hold_hi,
  input  logic            hold_lo,
  output logic [HI_W-1:0] cnt_hi,
  output logic [LO_W-1:0] cnt_lo,
  output logic            wrap
);

  logic [HI_W-1:0] hi_q, hi_d;
  logic [LO_W-1:0] lo_q, lo_d;
  logic            lo_step, carry, hi_step;

  always_comb begin
    lo_step = !hold_lo;
    carry   = lo_step && (&lo_q);
    hi_step = carry && !hold_hi;
    wrap    = !clear && hi_step && (&hi_q);
    if (clear) begin
      lo_d = '0;
      hi_d = '0;
    end else begin
      lo_d = lo_step ? lo_q + LO_W'(1) : lo_q;
      hi_d = hi_step ? hi_q + HI_W'(1) : hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt_hi = hi_q;
  assign cnt_lo = lo_q;

  p_lo_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !hold_lo) |=> (lo_q == $past(lo_q) + LO_W'(1)));

  p_lo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && hold_lo) |=> (lo_q == $past(lo_q)));

  p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && hold_hi) |=> (hi_q == $past(hi_q)));

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (lo_q == '0 && hi_q == '0));

  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (lo_q == '0 && hi_q == '0));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int HI_W = 8,
  parameter int LO_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HI_W-1:0] cnt_hi,
  input  logic [LO_W-1:0] cnt_lo,
  input  logic [HI_W-1:0] alm_hi,
  input  logic [LO_W-1:0] alm_lo,
  output logic            hit
);

  logic equal, equal_q;

  always_comb begin
    equal = (cnt_hi == alm_hi) && (cnt_lo == alm_lo);
    hit   = equal && !equal_q;
  end

  // reset to one so the all-zero state after reset is not taken as a new match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) equal_q <= 1'b1;
    else        equal_q <= equal;
  end

  p_hit_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer #(
  parameter int PER_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             hold,
  input  logic [PER_W-1:0] reload,
  output logic             fire
);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             en_q;
  logic             load, run;

  always_comb begin
    load = enable && !en_q;
    run  = enable && !hold && !load;
    fire = run && (cnt_q == '0);
    if (load)      cnt_d = reload;
    else if (fire) cnt_d = reload;
    else if (run)  cnt_d = cnt_q - PER_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= enable;
    end
  end

  p_reload_after_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == $past(reload)));

  p_load_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !en_q) |=> (cnt_q == $past(reload)));

  p_hold_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && en_q && hold) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_alarm_tick.sv
module rtc_alarm_tick
  import rtc_alarm_tick_pkg::*;
#(
  parameter int HI_W  = 8,
  parameter int LO_W  = 32,
  parameter int PER_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_rollover,
  output logic              irq_alarm,
  output logic              irq_tick
);

  logic            rst_meta_q, rst_sync_n;
  ctrl_t           ctrl_q, ctrl_d;
  logic [HI_W-1:0] alm_hi_q, alm_hi_d, shadow_q, shadow_d;
  logic [LO_W-1:0] alm_lo_q, alm_lo_d;
  logic [PER_W-1:0] reload_q, reload_d;
  logic            st_wrap_q, st_alarm_q, st_tick_q;
  logic            st_wrap_d, st_alarm_d, st_tick_d;
  logic [HI_W-1:0] cnt_hi;
  logic [LO_W-1:0] cnt_lo;
  logic            ev_wrap, ev_alarm, ev_tick;
  logic            wr_ctrl, wr_alm_lo, wr_alm_hi, wr_reload, wr_status, rd_lo;
  reg_addr_e       addr;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  rtc_split_counter #(.HI_W(HI_W), .LO_W(LO_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear   (ctrl_q.clear),
    .hold_hi (ctrl_q.hold_hi),
    .hold_lo (ctrl_q.hold_lo),
    .cnt_hi  (cnt_hi),
    .cnt_lo  (cnt_lo),
    .wrap    (ev_wrap)
  );

  rtc_alarm_match #(.HI_W(HI_W), .LO_W(LO_W)) u_alarm (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cnt_hi (cnt_hi),
    .cnt_lo (cnt_lo),
    .alm_hi (alm_hi_q),
    .alm_lo (alm_lo_q),
    .hit    (ev_alarm)
  );

  rtc_tick_timer #(.PER_W(PER_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .enable (ctrl_q.tick_en),
    .hold   (ctrl_q.tick_hold),
    .reload (reload_q),
    .fire   (ev_tick)
  );

  // decode
  always_comb begin
    addr      = reg_addr_e'(reg_addr);
    wr_ctrl   = reg_wr && (addr == ADDR_CTRL);
    wr_alm_lo = reg_wr && (addr == ADDR_ALM_LO);
    wr_alm_hi = reg_wr && (addr == ADDR_ALM_HI);
    wr_reload = reg_wr && (addr == ADDR_RELOAD);
    wr_status = reg_wr && (addr == ADDR_STATUS);
    rd_lo     = reg_rd && (addr == ADDR_CNT_LO);
  end

  // next state
  always_comb begin
    ctrl_d   = wr_ctrl   ? ctrl_t'(reg_wdata[CTRL_W-1:0]) : ctrl_q;
    alm_lo_d = wr_alm_lo ? reg_wdata[LO_W-1:0]            : alm_lo_q;
    alm_hi_d = wr_alm_hi ? reg_wdata[HI_W-1:0]            : alm_hi_q;
    reload_d = wr_reload ? reg_wdata[PER_W-1:0]           : reload_q;
    shadow_d = rd_lo     ? cnt_hi                          : shadow_q;
    st_wrap_d  = ev_wrap  || (st_wrap_q  && !(wr_status && reg_wdata[ST_WRAP]));
    st_alarm_d = ev_alarm || (st_alarm_q && !(wr_status && reg_wdata[ST_ALARM]));
    st_tick_d  = ev_tick  || (st_tick_q  && !(wr_status && reg_wdata[ST_TICK]));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q     <= '0;
      alm_lo_q   <= '0;
      alm_hi_q   <= '0;
      reload_q   <= '0;
      shadow_q   <= '0;
      st_wrap_q  <= 1'b0;
      st_alarm_q <= 1'b0;
      st_tick_q  <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      alm_lo_q   <= alm_lo_d;
      alm_hi_q   <= alm_hi_d;
      reload_q   <= reload_d;
      shadow_q   <= shadow_d;
      st_wrap_q  <= st_wrap_d;
      st_alarm_q <= st_alarm_d;
      st_tick_q  <= st_tick_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (addr)
      ADDR_CTRL:   reg_rdata = REG_W'(ctrl_q);
      ADDR_CNT_LO: reg_rdata = REG_W'(cnt_lo);
      ADDR_CNT_HI: reg_rdata = REG_W'(shadow_q);
      ADDR_ALM_LO: reg_rdata = REG_W'(alm_lo_q);
      ADDR_ALM_HI: reg_rdata = REG_W'(alm_hi_q);
      ADDR_RELOAD: reg_rdata = REG_W'(reload_q);
      ADDR_STATUS: begin
        reg_rdata[ST_WRAP]  = st_wrap_q;
        reg_rdata[ST_ALARM] = st_alarm_q;
        reg_rdata[ST_TICK]  = st_tick_q;
      end
      default:     reg_rdata = '0;
    endcase
  end

  assign irq_rollover = st_wrap_q;
  assign irq_alarm    = st_alarm_q;
  assign irq_tick     = st_tick_q;

  p_shadow_capture_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_lo |=> (shadow_q == $past(cnt_hi)));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_tick |=> irq_tick);

  p_w1c_clears_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_status && reg_wdata[ST_WRAP] && !ev_wrap) |=> !irq_rollover);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_alarm && !(wr_status && reg_wdata[ST_ALARM])) |=> irq_alarm);

  p_alarm_needs_event_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!irq_alarm && !ev_alarm) |=> !irq_alarm);

endmodule

// File: tb/rtc_alarm_tick_tb_top.sv
module rtc_alarm_tick_tb_top;
  import rtc_alarm_tick_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int HI_W  = 4;
  localparam int LO_W  = 10;
  localparam int PER_W = 8;
  localparam int LO_SPAN = 1 << LO_W;
  localparam int FULL_SPAN = 1 << (HI_W + LO_W);

  logic             clk;
  logic             rst_n;
  logic             reg_wr, reg_rd;
  logic [ADDR_W-1:0] reg_addr;
  logic [REG_W-1:0] reg_wdata, reg_rdata;
  logic             irq_rollover, irq_alarm, irq_tick;

  int checks = 0;
  int errors = 0;

  rtc_alarm_tick #(.HI_W(HI_W), .LO_W(LO_W), .PER_W(PER_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq_rollover (irq_rollover),
    .irq_alarm    (irq_alarm),
    .irq_tick     (irq_tick)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // every bus operation starts and ends at a falling edge and spans one clock
  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  // leaves the counter at zero in the cycle the task returns
  task automatic restart_counter();
    bus_write(3'd0, 32'h10);
    bus_write(3'd6, 32'hE000_0000);
    bus_write(3'd0, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(3'd0, v); check("R1 ctrl", v, 0);
    bus_read(3'd3, v); check("R1 alarm lo", v, 0);
    bus_read(3'd4, v); check("R1 alarm hi", v, 0);
    bus_read(3'd5, v); check("R1 reload", v, 0);
    bus_read(3'd6, v); check("R1 status", v, 0);
    check("R1 irqs", {29'd0, irq_rollover, irq_alarm, irq_tick}, 0);
  endtask

  task automatic t_count_and_carry();
    logic [31:0] lo, hi;
    restart_counter();
    idle(5);
    bus_read(3'd1, lo); check("R2 lo step", lo, 5);
    restart_counter();
    idle(1100);
    bus_read(3'd1, lo);
    bus_read(3'd2, hi);
    check("R2 carry lo", lo, 1100 % LO_SPAN);
    check("R2 carry hi", hi, 1100 / LO_SPAN);
  endtask

  task automatic t_hold();
    logic [31:0] a, b;
    bus_write(3'd0, 32'h4);
    idle(2);
    bus_read(3'd1, a);
    idle(7);
    bus_read(3'd1, b);
    check("R3 lo held", b, a);
    bus_write(3'd0, 32'h18);
    bus_write(3'd0, 32'h08);
    idle(1100);
    bus_read(3'd1, a);
    bus_read(3'd2, b);
    check("R3 hi held lo runs", a, 1100 % LO_SPAN);
    check("R3 hi held", b, 0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    bus_write(3'd0, 32'h10);
    idle(4);
    bus_read(3'd1, v); check("R4 clear lo", v, 0);
    idle(3);
    bus_read(3'd1, v); check("R4 clear stays", v, 0);
    bus_write(3'd0, 32'h0);
    bus_read(3'd1, v); check("R4 resume zero", v, 0);
    idle(5);
    bus_read(3'd1, v); check("R4 resume count", v, 6);
  endtask

  task automatic t_shadow();
    logic [31:0] lo, hi;
    restart_counter();
    idle(LO_SPAN - 1);
    bus_read(3'd1, lo);
    bus_read(3'd2, hi);
    check("R5 lo before carry", lo, LO_SPAN - 1);
    check("R5 hi from latch", hi, 0);
    bus_read(3'd1, lo);
    bus_read(3'd2, hi);
    check("R5 next lo", lo, 1);
    check("R5 next hi", hi, 1);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    bus_write(3'd4, 32'h0);
    bus_write(3'd3, 32'd50);
    restart_counter();
    idle(40);
    bus_read(3'd6, v); check("R6 before match", v & 32'h4000_0000, 0);
    idle(15);
    bus_read(3'd6, v); check("R6 after match", v & 32'h4000_0000, 32'h4000_0000);
    check("R6 irq_alarm", {31'd0, irq_alarm}, 1);
    bus_write(3'd4, 32'hFFFF_FF01);
    bus_read(3'd4, v); check("R6 hi masked", v, 1);
    bus_write(3'd3, 32'd5);
    restart_counter();
    idle(1000);
    bus_read(3'd6, v); check("R6 low-only no match", v & 32'h4000_0000, 0);
    idle(40);
    bus_read(3'd6, v); check("R6 full match", v & 32'h4000_0000, 32'h4000_0000);
  endtask

  task automatic t_rollover();
    logic [31:0] v;
    restart_counter();
    idle(FULL_SPAN - 4);
    bus_read(3'd6, v); check("R9 before wrap", v & 32'h8000_0000, 0);
    idle(10);
    bus_read(3'd6, v); check("R9 after wrap", v & 32'h8000_0000, 32'h8000_0000);
    check("R10 irq_rollover", {31'd0, irq_rollover}, 1);
    bus_write(3'd6, 32'h8000_0000);
    bus_read(3'd6, v); check("R10 w1c wrap", v & 32'h8000_0000, 0);
  endtask

  task automatic t_tick();
    logic [31:0] v;
    bus_write(3'd0, 32'h0);
    bus_write(3'd5, 32'd4);
    bus_write(3'd6, 32'hE000_0000);
    bus_write(3'd0, 32'h1);
    idle(5);
    check("R7 not yet", {31'd0, irq_tick}, 0);
    idle(1);
    check("R7 first tick", {31'd0, irq_tick}, 1);
    bus_write(3'd6, 32'h2000_0000);
    check("R10 w1c tick", {31'd0, irq_tick}, 0);
    idle(3);
    check("R7 gap", {31'd0, irq_tick}, 0);
    idle(1);
    check("R7 period N+1", {31'd0, irq_tick}, 1);
    // hold the countdown
    bus_write(3'd0, 32'h3);
    bus_write(3'd6, 32'h2000_0000);
    idle(20);
    check("R8 held no tick", {31'd0, irq_tick}, 0);
    // set wins over clear with a tick every cycle
    bus_write(3'd0, 32'h0);
    bus_write(3'd5, 32'd0);
    bus_write(3'd0, 32'h1);
    idle(3);
    bus_write(3'd6, 32'h2000_0000);
    check("R10 set wins", {31'd0, irq_tick}, 1);
    // control zero stops everything
    bus_write(3'd0, 32'h0);
    bus_write(3'd6, 32'h2000_0000);
    idle(20);
    bus_read(3'd6, v); check("R11 stopped", v & 32'h2000_0000, 0);
    bus_read(3'd0, v); check("R11 ctrl zero", v, 0);
  endtask

  initial begin
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_count_and_carry();
    t_hold();
    t_clear();
    t_shadow();
    t_alarm();
    t_rollover();
    t_tick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule